// File: doc/BRIEF.md
# Exception Control Register Unit

This unit holds the four system-control registers that a simple 32-bit RISC core needs for exception handling: the faulting-address register, the status register, the cause register and the exception return address register. The core reads any of them by register number through a combinational move-from port. It writes them through a move-to port that updates state on the next clock edge.

When the core signals an exception, the unit records the exception code and the PC of the offending instruction in one cycle. For address errors it also records the offending data or fetch address. In the same cycle it pushes the mode and interrupt-enable stack held in the low status bits. The handler entry address is always present on a constant output. A return-from-exception strobe pops the stack. The unit also combines the external interrupt lines with the status mask and the current enable bit to raise an interrupt request.

The reset input is asynchronous and active low. Inside the unit it is released through a two-stage synchronizer.

Top module: `exc_ctrl_regs`

## Requirements
- R1: Register number 8 reads the faulting address, 12 the status, 13 the cause and 14 the exception PC. Every other number reads zero. Status bits 31:16, 7:6 and cause bits 31:16, 7:6, 1:0 read zero. After reset every stored field is zero.
- R2: Status bits 15:8 hold one interrupt mask bit per line, with 1 meaning allowed. Status bits 5:0 hold three mode/enable pairs: current in 1:0, previous in 3:2, old in 5:4. In each pair the lower bit is the interrupt enable (1 = allowed) and the upper bit is the mode (0 = kernel, 1 = user). A move-to write to register 12 loads bits 15:8 and 5:0 from the write data.
- R3: On an exception, status bits 5:0 become {old bits 3:0, 2'b00}. The current pair is therefore kernel mode with interrupts disabled.
- R4: A return-from-exception strobe without an exception sets status bits 5:0 to {bits 5:4, bits 5:2}. It leaves the exception PC unchanged.
- R5: On an exception, cause bits 5:2 take the 4-bit exception code. Codes are 0 interrupt, 4 misaligned fetch or load, 5 misaligned store, 6 bad fetch address, 7 bad data read address, 8 syscall, 9 breakpoint, 10 reserved instruction and 12 overflow. A move-to write to register 13 loads bits 5:2 from write data bits 5:2, so writing zero clears the code.
- R6: On an exception, the exception PC register captures the faulting instruction address. A move-to write to register 14 loads it.
- R7: The faulting-address register captures the exception address only for codes 4 to 7. It holds its value for every other code, and move-to writes to register 8 have no effect.
- R8: Cause bits 15:8 show the current level of the interrupt lines.
- R9: The interrupt request output is high exactly when at least one line is high with its mask bit set and status bit 0 is 1.
- R10: In a cycle with an exception, any return strobe and any move-to write are ignored. In a cycle with a return strobe and no exception, any move-to write is ignored.
- R11: The handler vector output is always 0x80000080.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mt_en | input | 1 | Move-to write strobe |
| mt_sel | input | 5 | Register number for the write |
| mt_data | input | 32 | Write data |
| mf_sel | input | 5 | Register number for the read |
| mf_data | output | 32 | Read data (combinational) |
| exc_valid | input | 1 | Exception taken this cycle |
| exc_code | input | 4 | Exception code |
| exc_pc | input | 32 | PC of the faulting instruction |
| exc_addr | input | 32 | Offending address for address errors |
| rfe | input | 1 | Return-from-exception strobe |
| irq_lines | input | 8 | Pending interrupt lines |
| irq_req | output | 1 | Interrupt request to the core |
| vector_pc | output | 32 | Handler entry address |

## Verification
Three update sources can coincide in one cycle: an exception, a return strobe and a move-to write. The bench provokes every pairing directly. It drives an exception together with a status or PC write, an exception together with a return strobe, and a return strobe together with a PC write. It then reads the registers back on the next cycle. A behavioural model applies the fixed precedence, and the same collisions recur many times in a long stretch of random traffic that is compared on every cycle.

// File: rtl/exc_ctrl_pkg.sv
package exc_ctrl_pkg;
  localparam int unsigned REGSEL_W = 5;
  localparam int unsigned CODE_W   = 4;
  localparam int unsigned STK_W    = 6;

  localparam logic [REGSEL_W-1:0] SEL_BADADDR = 5'd8;
  localparam logic [REGSEL_W-1:0] SEL_STATUS  = 5'd12;
  localparam logic [REGSEL_W-1:0] SEL_CAUSE   = 5'd13;
  localparam logic [REGSEL_W-1:0] SEL_EPC     = 5'd14;

  typedef enum logic [CODE_W-1:0] {
    EC_IRQ         = 4'd0,
    EC_MISALIGN_LD = 4'd4,
    EC_MISALIGN_ST = 4'd5,
    EC_BAD_IFETCH  = 4'd6,
    EC_BAD_DREAD   = 4'd7,
    EC_SYSCALL     = 4'd8,
    EC_BREAK       = 4'd9,
    EC_RSVD_INSN   = 4'd10,
    EC_OVERFLOW    = 4'd12
  } exc_code_e;

  function automatic logic is_addr_err(input logic [CODE_W-1:0] code);
    return (code >= CODE_W'(EC_MISALIGN_LD)) && (code <= CODE_W'(EC_BAD_DREAD));
  endfunction
endpackage

// File: rtl/exc_mode_stack.sv
module exc_mode_stack #(
  parameter int unsigned NIRQ  = 8,
  parameter int unsigned STK_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exc_take,
  input  logic             ret_take,
  input  logic             wr_en,
  input  logic [NIRQ-1:0]  wr_mask,
  input  logic [STK_W-1:0] wr_stack,
  output logic [NIRQ-1:0]  mask_q,
  output logic [STK_W-1:0] stack_q
);
  logic [NIRQ-1:0]  mask_d;
  logic [STK_W-1:0] stack_d;
  logic             upd_en;

  assign upd_en = exc_take | ret_take | wr_en;

  always_comb begin
    mask_d  = mask_q;
    stack_d = stack_q;
    if (exc_take) begin
      stack_d = {stack_q[STK_W-3:0], 2'b00};
    end else if (ret_take) begin
      stack_d = {stack_q[STK_W-1:STK_W-2], stack_q[STK_W-1:2]};
    end else if (wr_en) begin
      mask_d  = wr_mask;
      stack_d = wr_stack;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      stack_q <= '0;
    end else if (upd_en) begin
      mask_q  <= mask_d;
      stack_q <= stack_d;
    end
  end
endmodule

// File: rtl/exc_cause_code.sv
module exc_cause_code #(
  parameter int unsigned CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_take,
  input  logic [CODE_W-1:0] exc_code,
  input  logic              wr_en,
  input  logic [CODE_W-1:0] wr_code,
  output logic [CODE_W-1:0] code_q
);
  logic [CODE_W-1:0] code_d;
  logic              upd_en;

  assign upd_en = exc_take | wr_en;

  always_comb begin
    code_d = code_q;
    if (exc_take)   code_d = exc_code;
    else if (wr_en) code_d = wr_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      code_q <= '0;
    else if (upd_en) code_q <= code_d;
  end
endmodule

// File: rtl/exc_addr_capture.sv
module exc_addr_capture #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_take,
  input  logic            addr_err,
  input  logic [XLEN-1:0] exc_pc,
  input  logic [XLEN-1:0] exc_addr,
  input  logic            epc_wr_en,
  input  logic [XLEN-1:0] epc_wr_data,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] badaddr_q
);
  logic [XLEN-1:0] epc_d;
  logic            epc_en;
  logic            bad_en;

  assign epc_en = exc_take | epc_wr_en;
  assign bad_en = exc_take & addr_err;
  assign epc_d  = exc_take ? exc_pc : epc_wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      epc_q <= '0;
    else if (epc_en) epc_q <= epc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      badaddr_q <= '0;
    else if (bad_en) badaddr_q <= exc_addr;
  end
endmodule

// File: rtl/exc_ctrl_regs.sv
module exc_ctrl_regs
  import exc_ctrl_pkg::*;
#(
  parameter int unsigned      XLEN   = 32,
  parameter int unsigned      NIRQ   = 8,
  parameter logic [XLEN-1:0]  VECTOR = 32'h8000_0080
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mt_en,
  input  logic [REGSEL_W-1:0] mt_sel,
  input  logic [XLEN-1:0]     mt_data,
  input  logic [REGSEL_W-1:0] mf_sel,
  output logic [XLEN-1:0]     mf_data,
  input  logic                exc_valid,
  input  logic [CODE_W-1:0]   exc_code,
  input  logic [XLEN-1:0]     exc_pc,
  input  logic [XLEN-1:0]     exc_addr,
  input  logic                rfe,
  input  logic [NIRQ-1:0]     irq_lines,
  output logic                irq_req,
  output logic [XLEN-1:0]     vector_pc
);
  localparam int unsigned IRQ_LSB = 8;
  localparam int unsigned IRQ_MSB = IRQ_LSB + NIRQ - 1;
  localparam int unsigned CODE_LSB = 2;
  localparam int unsigned CODE_MSB = CODE_LSB + CODE_W - 1;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              ret_take;
  logic              wr_ok;
  logic [NIRQ-1:0]   mask_q;
  logic [STK_W-1:0]  stack_q;
  logic [CODE_W-1:0] code_q;
  logic [XLEN-1:0]   epc_q;
  logic [XLEN-1:0]   badaddr_q;
  logic [XLEN-1:0]   status_rd;
  logic [XLEN-1:0]   cause_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign ret_take = rfe & ~exc_valid;
  assign wr_ok    = mt_en & ~exc_valid & ~rfe;

  exc_mode_stack #(.NIRQ(NIRQ), .STK_W(STK_W)) u_stack (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .exc_take (exc_valid),
    .ret_take (ret_take),
    .wr_en    (wr_ok && (mt_sel == SEL_STATUS)),
    .wr_mask  (mt_data[IRQ_MSB:IRQ_LSB]),
    .wr_stack (mt_data[STK_W-1:0]),
    .mask_q   (mask_q),
    .stack_q  (stack_q)
  );

  exc_cause_code #(.CODE_W(CODE_W)) u_cause (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .exc_take (exc_valid),
    .exc_code (exc_code),
    .wr_en    (wr_ok && (mt_sel == SEL_CAUSE)),
    .wr_code  (mt_data[CODE_MSB:CODE_LSB]),
    .code_q   (code_q)
  );

  exc_addr_capture #(.XLEN(XLEN)) u_addr (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .exc_take    (exc_valid),
    .addr_err    (is_addr_err(exc_code)),
    .exc_pc      (exc_pc),
    .exc_addr    (exc_addr),
    .epc_wr_en   (wr_ok && (mt_sel == SEL_EPC)),
    .epc_wr_data (mt_data),
    .epc_q       (epc_q),
    .badaddr_q   (badaddr_q)
  );

  always_comb begin
    status_rd                   = '0;
    status_rd[IRQ_MSB:IRQ_LSB]  = mask_q;
    status_rd[STK_W-1:0]        = stack_q;
    cause_rd                    = '0;
    cause_rd[IRQ_MSB:IRQ_LSB]   = irq_lines;
    cause_rd[CODE_MSB:CODE_LSB] = code_q;
  end

  always_comb begin
    case (mf_sel)
      SEL_BADADDR: mf_data = badaddr_q;
      SEL_STATUS:  mf_data = status_rd;
      SEL_CAUSE:   mf_data = cause_rd;
      SEL_EPC:     mf_data = epc_q;
      default:     mf_data = '0;
    endcase
  end

  assign irq_req   = stack_q[0] & (|(irq_lines & mask_q));
  assign vector_pc = VECTOR;
endmodule

// File: rtl/exc_ctrl_regs_chk.sv
module exc_ctrl_regs_chk #(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned NIRQ   = 8,
  parameter int unsigned CODE_W = 4,
  parameter int unsigned STK_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exc_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic [XLEN-1:0]   exc_pc,
  input logic              rfe,
  input logic              mt_en,
  input logic [4:0]        mt_sel,
  input logic [NIRQ-1:0]   irq_lines,
  input logic              irq_req,
  input logic [NIRQ-1:0]   mask_q,
  input logic [STK_W-1:0]  stack_q,
  input logic [CODE_W-1:0] code_q,
  input logic [XLEN-1:0]   epc_q,
  input logic [XLEN-1:0]   badaddr_q
);
  assert_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> stack_q == {$past(stack_q[STK_W-3:0]), 2'b00});

  assert_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !exc_valid) |=> stack_q == {$past(stack_q[STK_W-1:STK_W-2]), $past(stack_q[STK_W-1:2])});

  assert_epc_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rfe && !exc_valid) |=> $stable(epc_q));

  assert_code_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> code_q == $past(exc_code));

  assert_epc_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |=> epc_q == $past(exc_pc));

  assert_badaddr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(exc_valid && exc_code >= 4 && exc_code <= 7) |=> $stable(badaddr_q));

  assert_irq_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (stack_q[0] && (|(irq_lines & mask_q))));

  assert_exc_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid && mt_en && mt_sel == 5'd12) |=> $stable(mask_q));
endmodule

bind exc_ctrl_regs exc_ctrl_regs_chk #(
  .XLEN(XLEN), .NIRQ(NIRQ), .CODE_W(exc_ctrl_pkg::CODE_W), .STK_W(exc_ctrl_pkg::STK_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .exc_valid (exc_valid),
  .exc_code  (exc_code),
  .exc_pc    (exc_pc),
  .rfe       (rfe),
  .mt_en     (mt_en),
  .mt_sel    (mt_sel),
  .irq_lines (irq_lines),
  .irq_req   (irq_req),
  .mask_q    (mask_q),
  .stack_q   (stack_q),
  .code_q    (code_q),
  .epc_q     (epc_q),
  .badaddr_q (badaddr_q)
);

// File: tb/exc_ctrl_regs_tb.sv
module exc_ctrl_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        mt_en;
  logic [4:0]  mt_sel;
  logic [31:0] mt_data;
  logic [4:0]  mf_sel;
  logic [31:0] mf_data;
  logic        exc_valid;
  logic [3:0]  exc_code;
  logic [31:0] exc_pc;
  logic [31:0] exc_addr;
  logic        rfe;
  logic [7:0]  irq_lines;
  logic        irq_req;
  logic [31:0] vector_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_ctrl_regs u_dut (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .mt_sel(mt_sel), .mt_data(mt_data),
    .mf_sel(mf_sel), .mf_data(mf_data), .exc_valid(exc_valid), .exc_code(exc_code),
    .exc_pc(exc_pc), .exc_addr(exc_addr), .rfe(rfe), .irq_lines(irq_lines),
    .irq_req(irq_req), .vector_pc(vector_pc)
  );

  int n_cmp = 0;
  int n_bad = 0;

  // behavioural reference state
  bit [7:0]  m_mask;
  bit [5:0]  m_stk;
  bit [3:0]  m_code;
  bit [31:0] m_epc;
  bit [31:0] m_bad;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit [31:0] model_read(input bit [4:0] sel, input bit [7:0] lines);
    case (sel)
      5'd8:    return m_bad;
      5'd12:   return {16'h0, m_mask, 2'b00, m_stk};
      5'd13:   return {16'h0, lines, 2'b00, m_code, 2'b00};
      5'd14:   return m_epc;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input bit [4:0] sel);
    case (sel)
      5'd8:    return "R7";
      5'd12:   return "R3";
      5'd13:   return "R5";
      5'd14:   return "R6";
      default: return "R1";
    endcase
  endfunction

  task automatic step(input bit ex, input bit [3:0] code, input bit [31:0] pc,
                      input bit [31:0] addr, input bit rt, input bit we,
                      input bit [4:0] ws, input bit [31:0] wd, input bit [4:0] rs,
                      input bit [7:0] lines, input string tag);
    @(negedge clk);
    exc_valid = ex; exc_code = code; exc_pc = pc; exc_addr = addr;
    rfe = rt; mt_en = we; mt_sel = ws; mt_data = wd; mf_sel = rs; irq_lines = lines;
    #1;
    check(tag, mf_data, model_read(rs, lines));
    check("R9", {31'h0, irq_req}, {31'h0, m_stk[0] & (|(lines & m_mask))});
    check("R11", vector_pc, 32'h8000_0080);
    @(posedge clk);
    if (ex) begin
      m_stk  = {m_stk[3:0], 2'b00};
      m_code = code;
      m_epc  = pc;
      if (code >= 4 && code <= 7) m_bad = addr;
    end else if (rt) begin
      m_stk = {m_stk[5:4], m_stk[5:2]};
    end else if (we) begin
      case (ws)
        5'd12: begin m_mask = wd[15:8]; m_stk = wd[5:0]; end
        5'd13: m_code = wd[5:2];
        5'd14: m_epc  = wd;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input bit [4:0] rs, input bit [7:0] lines, input string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, rs, lines, tag);
  endtask

  task automatic wr(input bit [4:0] ws, input bit [31:0] wd);
    step(0, 0, 0, 0, 0, 1, ws, wd, 5'd0, 8'h0, "R1");
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    exc_valid = 0; exc_code = 0; exc_pc = 0; exc_addr = 0; rfe = 0;
    mt_en = 0; mt_sel = 0; mt_data = 0; mf_sel = 0; irq_lines = 0;
    m_mask = 0; m_stk = 0; m_code = 0; m_epc = 0; m_bad = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values and decoding, including unused numbers
    rd(5'd8, 8'h0, "R1"); rd(5'd12, 8'h0, "R1"); rd(5'd13, 8'h0, "R1");
    rd(5'd14, 8'h0, "R1"); rd(5'd0, 8'h0, "R1"); rd(5'd31, 8'h0, "R1");
    rd(5'd9, 8'h0, "R1");
    // R2: status write, unused bits read zero
    wr(5'd12, 32'hFFFF_FF3F);
    rd(5'd12, 8'h0, "R2");
    // R3: three pushes
    step(1, 4'd8, 32'h100, 32'h0, 0, 0, 0, 0, 5'd12, 8'h0, "R3");
    rd(5'd12, 8'h0, "R3");
    step(1, 4'd9, 32'h104, 32'h0, 0, 0, 0, 0, 5'd12, 8'h0, "R3");
    rd(5'd12, 8'h0, "R3");
    step(1, 4'd10, 32'h108, 32'h0, 0, 0, 0, 0, 5'd12, 8'h0, "R3");
    rd(5'd12, 8'h0, "R3");
    // R4: pops, exception PC untouched
    wr(5'd12, 32'h0000_0025);
    step(0, 0, 0, 0, 1, 0, 0, 0, 5'd14, 8'h0, "R4");
    rd(5'd12, 8'h0, "R4"); rd(5'd14, 8'h0, "R4");
    step(0, 0, 0, 0, 1, 0, 0, 0, 5'd12, 8'h0, "R4");
    rd(5'd12, 8'h0, "R4");
    // R5: code capture, clear by writing zero, write of a code
    step(1, 4'd12, 32'h200, 32'h0, 0, 0, 0, 0, 5'd13, 8'h0, "R5");
    rd(5'd13, 8'h0, "R5");
    wr(5'd13, 32'h0);
    rd(5'd13, 8'h0, "R5");
    wr(5'd13, 32'hFFFF_FFE8);
    rd(5'd13, 8'h0, "R5");
    // R6: PC capture and write
    step(1, 4'd8, 32'hDEAD_BEE0, 32'h0, 0, 0, 0, 0, 5'd14, 8'h0, "R6");
    rd(5'd14, 8'h0, "R6");
    wr(5'd14, 32'h0040_1234);
    rd(5'd14, 8'h0, "R6");
    // R7: address captured for codes 4..7 only, writes ignored
    step(1, 4'd4, 32'h300, 32'hAAAA_0001, 0, 0, 0, 0, 5'd8, 8'h0, "R7");
    rd(5'd8, 8'h0, "R7");
    step(1, 4'd7, 32'h304, 32'hBBBB_0002, 0, 0, 0, 0, 5'd8, 8'h0, "R7");
    rd(5'd8, 8'h0, "R7");
    step(1, 4'd9, 32'h308, 32'hCCCC_0003, 0, 0, 0, 0, 5'd8, 8'h0, "R7");
    rd(5'd8, 8'h0, "R7");
    step(1, 4'd3, 32'h30C, 32'hDDDD_0004, 0, 0, 0, 0, 5'd8, 8'h0, "R7");
    rd(5'd8, 8'h0, "R7");
    wr(5'd8, 32'h1234_5678);
    rd(5'd8, 8'h0, "R7");
    // R8: pending lines mirrored in cause
    rd(5'd13, 8'hA5, "R8"); rd(5'd13, 8'h5A, "R8"); rd(5'd13, 8'hFF, "R8");
    // R9: masking and global enable
    wr(5'd12, 32'h0000_0501);
    rd(5'd12, 8'h02, "R9"); rd(5'd12, 8'h04, "R9"); rd(5'd12, 8'h01, "R9");
    wr(5'd12, 32'h0000_0500);
    rd(5'd12, 8'h05, "R9");
    // R10: collisions
    wr(5'd12, 32'h0000_FF15);
    step(1, 4'd8, 32'h400, 32'h0, 0, 1, 5'd12, 32'h0000_003F, 5'd12, 8'h0, "R10");
    rd(5'd12, 8'h0, "R10");
    step(1, 4'd9, 32'h404, 32'h0, 0, 1, 5'd14, 32'h0000_7777, 5'd14, 8'h0, "R10");
    rd(5'd14, 8'h0, "R10");
    wr(5'd12, 32'h0000_0015);
    step(1, 4'd10, 32'h408, 32'h0, 1, 0, 0, 0, 5'd12, 8'h0, "R10");
    rd(5'd12, 8'h0, "R10");
    step(0, 0, 0, 0, 1, 1, 5'd14, 32'h0000_9999, 5'd14, 8'h0, "R10");
    rd(5'd14, 8'h0, "R10"); rd(5'd12, 8'h0, "R10");
    step(0, 0, 0, 0, 1, 1, 5'd13, 32'h0000_0030, 5'd13, 8'h0, "R10");
    rd(5'd13, 8'h0, "R10");
    // random traffic, compared every cycle
    for (int i = 0; i < 4000; i++) begin
      bit [4:0] pick [5] = '{5'd8, 5'd12, 5'd13, 5'd14, 5'd3};
      bit [4:0] ws = pick[$urandom_range(0, 4)];
      bit [4:0] rs = pick[$urandom_range(0, 4)];
      step(($urandom_range(0, 5) == 0), 4'($urandom), $urandom, $urandom,
           ($urandom_range(0, 4) == 0), ($urandom_range(0, 2) == 0), ws, $urandom,
           rs, 8'($urandom), tag_of(rs));
    end
    finish_run();
  end
endmodule